// File: doc/BRIEF.md
# Operating-Point Table Rounding Engine

This block keeps a small table of operating points (a frequency paired with a supply voltage) for each cluster of a multi-cluster processor. The table is filled one packed 32-bit word at a time. Each word carries a frequency count in 20 kHz steps in its low part and a voltage in millivolts in its high part. The block decodes every entry to kilohertz and microvolts.

A client hands in a target frequency in kHz and picks one of two lookups. The rounding lookup returns the nearest supported point, preferring one at or above the target. The exact lookup returns the position of a point that matches the target, or an error when no point matches. The sequencer walks the selected table one entry per clock. It then pulses a done strobe and holds the result until the next one.

A combinational peek port reads back any single entry and shows whether that entry lies inside the table.

Top module: `opp_round_engine`

## Requirements
- R1: A loaded word is split into a voltage field in bits 31:20 (millivolts) and a frequency field in bits 19:0 (20 kHz steps). The peek port reports the entry as field×20 kHz and field×1000 µV. Accepted words fill positions 0, 1, 2 … in arrival order.
- R2: A load with `ld_restart`=1 starts a fresh table for that cluster, and that load is the first word of the new table. Further loads append until the table holds ENTRIES (8) words, and any load after that is dropped. A load with `ld_ok`=0 stores nothing and freezes the length. All later loads to that cluster are then dropped until the next restart.
- R3: `peek_valid` is 1 only when `peek_index` is below the cluster's current length. When it is 0, `peek_khz` and `peek_uv` read 0.
- R4: The rounding lookup (`req_exact`=0) returns the smallest table frequency that is at or above `req_khz`. When several entries share that frequency, the lowest position wins. `rsp_error` is 0.
- R5: When every entry lies below the target, the rounding lookup returns the largest frequency, with the lowest position winning a tie.
- R6: The exact lookup (`req_exact`=1) returns the lowest position whose frequency equals `req_khz`, together with that entry's frequency and voltage. When no entry matches, it sets `rsp_error`=1 and returns index, frequency and voltage all 0.
- R7: Any lookup on an empty table gives `rsp_error`=1 and zero index, frequency and voltage.
- R8: `rsp_done` is high for exactly one cycle, max(N,1) clock edges after the edge that accepted the request, where N is the table length. The `rsp_*` result outputs keep their values until the next done pulse.
- R9: `req_ready` falls on the edge after a request is accepted and rises again in the done cycle. A request made while `req_ready` is 0 is not taken.
- R10: `ld_ready` is 1 only while no lookup is running and `req_valid` is 0. A load offered while `ld_ready` is 0 changes no table.
- R11: Each cluster has its own table and its own length. Loads and lookups touch only the cluster they name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load can be taken this cycle |
| ld_cluster | input | CL_W | Cluster whose table is loaded |
| ld_restart | input | 1 | This load starts a new table |
| ld_ok | input | 1 | 1 = word fetched correctly, 0 = fetch failed (ends table) |
| ld_word | input | 32 | Packed entry word |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_cluster | input | CL_W | Cluster to search |
| req_exact | input | 1 | 0 = rounding lookup, 1 = exact lookup |
| req_khz | input | 25 | Target frequency in kHz |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_error | output | 1 | No result (empty table or exact miss) |
| rsp_index | output | IDX_W | Position of the chosen entry |
| rsp_khz | output | 25 | Chosen frequency in kHz |
| rsp_uv | output | 22 | Chosen voltage in microvolts |
| peek_cluster | input | CL_W | Cluster to read back |
| peek_index | input | IDX_W | Entry to read back |
| peek_valid | output | 1 | Entry lies inside the table |
| peek_khz | output | 25 | Entry frequency in kHz |
| peek_uv | output | 22 | Entry voltage in microvolts |

## Verification
A lookup result is due max(N,1) edges after the accepting edge. The bench's behavioural model therefore counts that many rising edges down before it expects `rsp_done` and the new values. On every falling edge it compares the strobe, both ready outputs and the held result with the model. Loads take effect on the edge after they are offered. Peek reads are combinational, so they are compared 1 ns after the peek inputs change. Both ready outputs are checked every cycle, so a load or request offered during a scan has to leave the table and the result intact through the done cycle.

// File: rtl/opp_pkg.sv
package opp_pkg;

    localparam int WORD_W       = 32;
    localparam int FSTEP_W      = 20;
    localparam int MV_W         = 12;
    localparam int KHZ_W        = 25;
    localparam int UV_W         = 22;
    localparam int KHZ_PER_STEP = 20;
    localparam int UV_PER_MV    = 1000;

    // voltage sits above frequency; field positions are fixed by the word format
    typedef struct packed {
        logic [MV_W-1:0]    mv;
        logic [FSTEP_W-1:0] steps;
    } opp_word_t;

    typedef enum logic {
        MODE_ROUND = 1'b0,
        MODE_EXACT = 1'b1
    } opp_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SCAN = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [KHZ_W-1:0] khz;
        logic [UV_W-1:0]  uv;
    } opp_point_t;

    function automatic opp_point_t decode_word(input opp_word_t w);
        opp_point_t p;
        p.khz = KHZ_W'(w.steps) * KHZ_W'(KHZ_PER_STEP);
        p.uv  = UV_W'(w.mv) * UV_W'(UV_PER_MV);
        return p;
    endfunction

endpackage

// File: rtl/opp_table.sv
module opp_table
    import opp_pkg::*;
#(
    parameter int CLUSTERS = 2,
    parameter int ENTRIES  = 8,
    parameter int CL_W     = 1,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CL_W-1:0]  wr_cl,
    input  logic             wr_restart,
    input  logic             wr_ok,
    input  opp_word_t        wr_word,
    input  logic [CL_W-1:0]  rd_cl,
    input  logic [IDX_W-1:0] rd_idx,
    output opp_word_t        rd_word,
    input  logic [CL_W-1:0]  cnt_cl,
    output logic [CNT_W-1:0] cnt_out,
    input  logic [CL_W-1:0]  pk_cl,
    input  logic [IDX_W-1:0] pk_idx,
    output logic             pk_hit,
    output opp_word_t        pk_word
);

    opp_word_t        mem  [CLUSTERS][ENTRIES];
    logic [CNT_W-1:0] cnt  [CLUSTERS];
    logic             halt [CLUSTERS];

    for (genvar c = 0; c < CLUSTERS; c++) begin : g_cl
        logic             sel;
        logic [CNT_W-1:0] base_cnt;
        logic             base_halt;
        logic             append;

        always_comb begin
            sel       = wr_en && (int'(wr_cl) == c);
            base_cnt  = wr_restart ? '0 : cnt[c];
            base_halt = wr_restart ? 1'b0 : halt[c];
            append    = sel && wr_ok && !base_halt && (base_cnt < CNT_W'(ENTRIES));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[c]  <= '0;
                halt[c] <= 1'b0;
                for (int e = 0; e < ENTRIES; e++) begin
                    mem[c][e] <= '0;
                end
            end else if (sel) begin
                cnt[c]  <= append ? base_cnt + 1'b1 : base_cnt;
                halt[c] <= base_halt || !wr_ok;
                for (int e = 0; e < ENTRIES; e++) begin
                    if (append && base_cnt == CNT_W'(e)) begin
                        mem[c][e] <= wr_word;
                    end
                end
            end
        end

        // R2
        cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
            cnt[c] <= CNT_W'(ENTRIES));

        // R2
        halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
            (halt[c] && !(sel && wr_restart)) |=> $stable(cnt[c]));
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_cl) < CLUSTERS && int'(rd_idx) < ENTRIES) begin
            rd_word = mem[rd_cl][rd_idx];
        end
    end

    always_comb begin
        cnt_out = '0;
        if (int'(cnt_cl) < CLUSTERS) begin
            cnt_out = cnt[cnt_cl];
        end
    end

    always_comb begin
        pk_hit  = 1'b0;
        pk_word = '0;
        if (int'(pk_cl) < CLUSTERS && int'(pk_idx) < ENTRIES) begin
            pk_hit = CNT_W'(pk_idx) < cnt[pk_cl];
            if (pk_hit) begin
                pk_word = mem[pk_cl][pk_idx];
            end
        end
    end

endmodule

// File: rtl/opp_scan.sv
module opp_scan
    import opp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CL_W    = 1,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CL_W-1:0]  start_cl,
    input  opp_mode_e        start_mode,
    input  logic [KHZ_W-1:0] start_khz,
    input  logic [CNT_W-1:0] start_cnt,
    output logic             busy,
    output logic [CL_W-1:0]  rd_cl,
    output logic [IDX_W-1:0] rd_idx,
    input  opp_word_t        rd_word,
    output logic             done,
    output logic             err,
    output logic [IDX_W-1:0] res_idx,
    output opp_point_t       res_pt
);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        opp_point_t       pt;
    } cand_t;

    seq_state_e       st;
    logic [IDX_W-1:0] idx;
    logic [CL_W-1:0]  cl_q;
    opp_mode_e        mode_q;
    logic [KHZ_W-1:0] tgt_q;
    logic [CNT_W-1:0] n_q;
    logic [CNT_W-1:0] scan_len;

    cand_t      up_q, dn_q, mt_q;
    cand_t      up_n, dn_n, mt_n, fin;
    opp_point_t cur;
    logic       last;

    always_comb begin
        cur  = decode_word(rd_word);
        up_n = up_q;
        dn_n = dn_q;
        mt_n = mt_q;
        if (cur.khz >= tgt_q && (!up_q.hit || cur.khz < up_q.pt.khz)) begin
            up_n = '{hit: 1'b1, idx: idx, pt: cur};
        end
        if (cur.khz < tgt_q && (!dn_q.hit || cur.khz > dn_q.pt.khz)) begin
            dn_n = '{hit: 1'b1, idx: idx, pt: cur};
        end
        if (cur.khz == tgt_q && !mt_q.hit) begin
            mt_n = '{hit: 1'b1, idx: idx, pt: cur};
        end
        last = (n_q == '0) || (CNT_W'(idx) == n_q - 1'b1);
        if (n_q == '0) begin
            fin = '0;
        end else if (mode_q == MODE_EXACT) begin
            fin = mt_n;
        end else begin
            fin = up_n.hit ? up_n : dn_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SEQ_IDLE;
            idx     <= '0;
            cl_q    <= '0;
            mode_q  <= MODE_ROUND;
            tgt_q   <= '0;
            n_q     <= '0;
            up_q    <= '0;
            dn_q    <= '0;
            mt_q    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            res_idx <= '0;
            res_pt  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        st     <= SEQ_SCAN;
                        idx    <= '0;
                        cl_q   <= start_cl;
                        mode_q <= start_mode;
                        tgt_q  <= start_khz;
                        n_q    <= start_cnt;
                        up_q   <= '0;
                        dn_q   <= '0;
                        mt_q   <= '0;
                    end
                end
                default: begin
                    up_q <= up_n;
                    dn_q <= dn_n;
                    mt_q <= mt_n;
                    idx  <= idx + 1'b1;
                    if (last) begin
                        st      <= SEQ_IDLE;
                        done    <= 1'b1;
                        err     <= !fin.hit;
                        res_idx <= fin.hit ? fin.idx : '0;
                        res_pt  <= fin.hit ? fin.pt : '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || st == SEQ_IDLE) begin
            scan_len <= '0;
        end else begin
            scan_len <= scan_len + 1'b1;
        end
    end

    assign busy   = (st == SEQ_SCAN);
    assign rd_cl  = cl_q;
    assign rd_idx = idx;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    scan_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_SCAN) |-> (scan_len < CNT_W'(ENTRIES)));

    // R6
    exact_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err && mode_q == MODE_EXACT) |-> (res_pt.khz == tgt_q));

    // R4
    round_up_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err && mode_q == MODE_ROUND && up_q.hit) |-> (res_pt.khz >= tgt_q));

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (res_pt == '0 && res_idx == '0));

endmodule

// File: rtl/opp_round_engine.sv
module opp_round_engine
    import opp_pkg::*;
#(
    parameter int CLUSTERS = 2,
    parameter int ENTRIES  = 8,
    localparam int CL_W  = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [CL_W-1:0]   ld_cluster,
    input  logic              ld_restart,
    input  logic              ld_ok,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CL_W-1:0]   req_cluster,
    input  logic              req_exact,
    input  logic [KHZ_W-1:0]  req_khz,
    output logic              rsp_done,
    output logic              rsp_error,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [KHZ_W-1:0]  rsp_khz,
    output logic [UV_W-1:0]   rsp_uv,
    input  logic [CL_W-1:0]   peek_cluster,
    input  logic [IDX_W-1:0]  peek_index,
    output logic              peek_valid,
    output logic [KHZ_W-1:0]  peek_khz,
    output logic [UV_W-1:0]   peek_uv
);

    logic             busy;
    logic             start;
    logic             wr_en;
    logic [CL_W-1:0]  scan_cl;
    logic [IDX_W-1:0] scan_idx;
    opp_word_t        scan_word;
    logic [CNT_W-1:0] sel_cnt;
    opp_word_t        pk_word;
    opp_point_t       pk_pt;
    opp_point_t       res_pt;

    assign req_ready = !busy;
    assign ld_ready  = !busy && !req_valid;
    assign start     = req_valid && req_ready;
    assign wr_en     = ld_valid && ld_ready;

    opp_table #(
        .CLUSTERS (CLUSTERS),
        .ENTRIES  (ENTRIES),
        .CL_W     (CL_W),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_cl      (ld_cluster),
        .wr_restart (ld_restart),
        .wr_ok      (ld_ok),
        .wr_word    (opp_word_t'(ld_word)),
        .rd_cl      (scan_cl),
        .rd_idx     (scan_idx),
        .rd_word    (scan_word),
        .cnt_cl     (req_cluster),
        .cnt_out    (sel_cnt),
        .pk_cl      (peek_cluster),
        .pk_idx     (peek_index),
        .pk_hit     (peek_valid),
        .pk_word    (pk_word)
    );

    opp_scan #(
        .ENTRIES (ENTRIES),
        .CL_W    (CL_W),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_scan (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_cl   (req_cluster),
        .start_mode (opp_mode_e'(req_exact)),
        .start_khz  (req_khz),
        .start_cnt  (sel_cnt),
        .busy       (busy),
        .rd_cl      (scan_cl),
        .rd_idx     (scan_idx),
        .rd_word    (scan_word),
        .done       (rsp_done),
        .err        (rsp_error),
        .res_idx    (rsp_index),
        .res_pt     (res_pt)
    );

    assign pk_pt    = decode_word(pk_word);
    assign peek_khz = pk_pt.khz;
    assign peek_uv  = pk_pt.uv;
    assign rsp_khz  = res_pt.khz;
    assign rsp_uv   = res_pt.uv;

    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    ld_block_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(!ld_ready));

endmodule

// File: tb/opp_round_engine_tb.sv
module opp_round_engine_tb;

    localparam int CLUSTERS = 2;
    localparam int ENTRIES  = 8;
    localparam int CL_W     = 1;
    localparam int IDX_W    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ld_valid = 1'b0, ld_restart = 1'b0, ld_ok = 1'b1;
    logic [CL_W-1:0]  ld_cluster = '0;
    logic [31:0]      ld_word = '0;
    logic             req_valid = 1'b0, req_exact = 1'b0;
    logic [CL_W-1:0]  req_cluster = '0;
    logic [24:0]      req_khz = '0;
    logic [CL_W-1:0]  peek_cluster = '0;
    logic [IDX_W-1:0] peek_index = '0;
    logic             ld_ready, req_ready, rsp_done, rsp_error, peek_valid;
    logic [IDX_W-1:0] rsp_index;
    logic [24:0]      rsp_khz, peek_khz;
    logic [21:0]      rsp_uv, peek_uv;

    always #5 clk = ~clk;

    opp_round_engine #(.CLUSTERS(CLUSTERS), .ENTRIES(ENTRIES)) u_dut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_cluster(ld_cluster),
        .ld_restart(ld_restart), .ld_ok(ld_ok), .ld_word(ld_word),
        .req_valid(req_valid), .req_ready(req_ready), .req_cluster(req_cluster),
        .req_exact(req_exact), .req_khz(req_khz),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_index(rsp_index),
        .rsp_khz(rsp_khz), .rsp_uv(rsp_uv),
        .peek_cluster(peek_cluster), .peek_index(peek_index),
        .peek_valid(peek_valid), .peek_khz(peek_khz), .peek_uv(peek_uv)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_word [CLUSTERS][ENTRIES];
    int     m_cnt  [CLUSTERS];
    bit     m_halt [CLUSTERS];
    bit     m_busy, m_done;
    int     m_left;
    bit     p_err, e_err;
    int     p_idx, e_idx;
    longint p_khz, p_uv, e_khz, e_uv;
    string  p_tag, e_tag;

    function automatic longint w_khz(input logic [31:0] w);
        return longint'(w[19:0]) * 20;
    endfunction

    function automatic longint w_uv(input logic [31:0] w);
        return longint'(w[31:20]) * 1000;
    endfunction

    task automatic model_lookup(input int cl, input bit exact, input longint tgt);
        int bu, bd, bm;
        bu = -1; bd = -1; bm = -1;
        for (int i = 0; i < m_cnt[cl]; i++) begin
            longint k;
            k = w_khz(m_word[cl][i]);
            if (k >= tgt && (bu < 0 || k < w_khz(m_word[cl][bu]))) bu = i;
            if (k < tgt && (bd < 0 || k > w_khz(m_word[cl][bd]))) bd = i;
            if (k == tgt && bm < 0) bm = i;
        end
        p_err = 1; p_idx = 0; p_khz = 0; p_uv = 0;
        if (m_cnt[cl] == 0) begin
            p_tag = "R7";
        end else if (exact) begin
            p_tag = "R6";
            if (bm >= 0) begin
                p_err = 0; p_idx = bm;
            end
        end else begin
            p_err = 0;
            if (bu >= 0) begin p_tag = "R4"; p_idx = bu; end
            else begin p_tag = "R5"; p_idx = bd; end
        end
        if (!p_err) begin
            p_khz = w_khz(m_word[cl][p_idx]);
            p_uv  = w_uv(m_word[cl][p_idx]);
        end
    endtask

    always @(posedge clk) begin
        int c, bc;
        bit bh;
        if (rst) begin
            for (int i = 0; i < CLUSTERS; i++) begin
                m_cnt[i] = 0; m_halt[i] = 0;
                for (int j = 0; j < ENTRIES; j++) m_word[i][j] = '0;
            end
            m_busy = 0; m_done = 0; m_left = 0;
            e_err = 0; e_idx = 0; e_khz = 0; e_uv = 0; e_tag = "R8";
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1;
                    e_err = p_err; e_idx = p_idx; e_khz = p_khz; e_uv = p_uv; e_tag = p_tag;
                end
            end else if (req_valid) begin
                model_lookup(int'(req_cluster), req_exact, longint'(req_khz));
                m_left = (m_cnt[req_cluster] == 0) ? 1 : m_cnt[req_cluster];
                m_busy = 1;
            end else if (ld_valid) begin
                c  = int'(ld_cluster);
                bc = ld_restart ? 0 : m_cnt[c];
                bh = ld_restart ? 1'b0 : m_halt[c];
                if (!ld_ok) begin
                    m_cnt[c] = bc; m_halt[c] = 1;
                end else if (!bh && bc < ENTRIES) begin
                    m_word[c][bc] = ld_word; m_cnt[c] = bc + 1; m_halt[c] = bh;
                end else begin
                    m_cnt[c] = bc; m_halt[c] = bh;
                end
            end
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        string t;
        if (!rst) begin
            t = m_done ? e_tag : "R8";
            chk(req_ready == !m_busy, "R9", "req_ready", longint'(req_ready), longint'(!m_busy));
            chk(ld_ready == (!m_busy && !req_valid), "R10", "ld_ready",
                longint'(ld_ready), longint'(!m_busy && !req_valid));
            chk(rsp_done == m_done, "R8", "rsp_done", longint'(rsp_done), longint'(m_done));
            chk(rsp_error == e_err, t, "rsp_error", longint'(rsp_error), longint'(e_err));
            chk(int'(rsp_index) == e_idx, t, "rsp_index", longint'(rsp_index), longint'(e_idx));
            chk(longint'(rsp_khz) == e_khz, t, "rsp_khz", longint'(rsp_khz), e_khz);
            chk(longint'(rsp_uv) == e_uv, t, "rsp_uv", longint'(rsp_uv), e_uv);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mk(input int mv, input int steps);
        return {mv[11:0], steps[19:0]};
    endfunction

    task automatic do_load(input int cl, input bit rs, input bit ok, input logic [31:0] w);
        @(negedge clk); #1;
        ld_valid = 1; ld_cluster = CL_W'(cl); ld_restart = rs; ld_ok = ok; ld_word = w;
        @(negedge clk); #1;
        ld_valid = 0; ld_restart = 0; ld_ok = 1;
    endtask

    task automatic do_req(input int cl, input bit exact, input longint khz);
        @(negedge clk); #1;
        req_valid = 1; req_cluster = CL_W'(cl); req_exact = exact; req_khz = 25'(khz);
        @(negedge clk); #1;
        req_valid = 0;
        repeat (ENTRIES + 2) @(negedge clk);
    endtask

    task automatic peek_chk(input int cl, input int idx, input string tag);
        bit v;
        #2;
        peek_cluster = CL_W'(cl); peek_index = IDX_W'(idx);
        #1;
        v = idx < m_cnt[cl];
        chk(peek_valid == v, tag, "peek_valid", longint'(peek_valid), longint'(v));
        chk(longint'(peek_khz) == (v ? w_khz(m_word[cl][idx]) : 0), tag, "peek_khz",
            longint'(peek_khz), v ? w_khz(m_word[cl][idx]) : 0);
        chk(longint'(peek_uv) == (v ? w_uv(m_word[cl][idx]) : 0), tag, "peek_uv",
            longint'(peek_uv), v ? w_uv(m_word[cl][idx]) : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        #1;
        // reset state
        chk(req_ready == 1, "R9", "reset req_ready", longint'(req_ready), 1);
        chk(rsp_done == 0, "R8", "reset rsp_done", longint'(rsp_done), 0);
        peek_chk(0, 0, "R3");

        // cluster 0: 1.0 GHz, 600 MHz, 1.2 GHz, 600 MHz (dup), 800 MHz
        do_load(0, 1, 1, mk(900, 50000));
        do_load(0, 0, 1, mk(800, 30000));
        do_load(0, 0, 1, mk(1000, 60000));
        do_load(0, 0, 1, mk(850, 30000));
        do_load(0, 0, 1, mk(950, 40000));
        for (int i = 0; i < 5; i++) peek_chk(0, i, "R1");
        peek_chk(0, 5, "R3");
        peek_chk(1, 0, "R11");

        do_req(0, 0, 800000);   // R4 exact-valued round
        do_req(0, 0, 700000);   // R4 round up
        do_req(0, 0, 500000);   // R4 tie -> lowest index
        do_req(0, 0, 0);        // R4 below all
        do_req(0, 0, 1300000);  // R5 fallback
        do_req(0, 1, 600000);   // R6 duplicate hit
        do_req(0, 1, 1000000);  // R6 hit index 0
        do_req(0, 1, 700000);   // R6 miss

        // cluster 1 empty
        do_req(1, 0, 5);        // R7
        do_req(1, 1, 0);        // R7

        // cluster 1: fill past capacity (R2)
        for (int i = 0; i < ENTRIES + 1; i++) do_load(1, i == 0, 1, mk(500 + i, 1000 * (i + 1)));
        for (int i = 0; i < ENTRIES; i++) peek_chk(1, i, "R2");
        do_req(1, 0, 30000);
        do_req(1, 0, 999999);   // R5 -> index 7

        // failed load ends table (R2)
        do_load(1, 1, 1, mk(700, 7000));
        do_load(1, 1'b0, 1, mk(710, 3000));
        do_load(1, 0, 0, mk(720, 5000));
        do_load(1, 0, 1, mk(730, 9000));
        peek_chk(1, 1, "R2");
        peek_chk(1, 2, "R2");
        do_req(1, 0, 200000);
        do_load(1, 1, 0, mk(1, 1));     // restart with failure -> empty
        peek_chk(1, 0, "R2");
        do_req(1, 0, 1);

        // loads and requests offered during a scan are ignored (R9, R10)
        @(negedge clk); #1;
        req_valid = 1; req_cluster = 0; req_exact = 0; req_khz = 25'd900000;
        @(negedge clk); #1;
        req_valid = 0;
        ld_valid = 1; ld_cluster = 0; ld_restart = 1; ld_ok = 0;
        @(negedge clk); #1;
        req_valid = 1; req_exact = 1; req_khz = 25'd1200000;
        @(negedge clk); #1;
        req_valid = 0;
        @(negedge clk); #1;
        ld_valid = 0; ld_restart = 0; ld_ok = 1;
        repeat (ENTRIES + 2) @(negedge clk);
        peek_chk(0, 4, "R10");

        // simultaneous request and load: load refused (R10)
        @(negedge clk); #1;
        req_valid = 1; req_cluster = 0; req_exact = 1; req_khz = 25'd800000;
        ld_valid = 1; ld_cluster = 0; ld_restart = 1; ld_ok = 0;
        @(negedge clk); #1;
        req_valid = 0; ld_valid = 0; ld_restart = 0; ld_ok = 1;
        repeat (ENTRIES + 2) @(negedge clk);
        peek_chk(0, 4, "R10");

        // back-to-back requests held valid (R9)
        @(negedge clk); #1;
        req_valid = 1; req_cluster = 0; req_exact = 0; req_khz = 25'd1100000;
        repeat (14) @(negedge clk);
        #1 req_valid = 0;
        repeat (ENTRIES + 2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule